// File: doc/BRIEF.md
# Boot Image Checksum Gate

This block runs once after every reset. It walks a 256-byte configuration image held in an external non-volatile memory and fetches one byte at a time through a simple byte-read port. The read-side protocol engine sits outside the block. The block copies each byte into a local shadow store and folds it into an 8-bit running sum. After the final byte it decides whether the device may leave reset. A good image is one whose 256 bytes, including the trailing check byte, add up to zero modulo 256.

The verdict drives two outputs. A checksum-good flag reports whether the image summed to zero. A start-enable output lets the rest of the device begin operating. In unmanaged operation the start-enable follows the checksum verdict, so a corrupt image keeps the device halted. In managed operation the verdict is still reported, but start is allowed whatever the sum.

After the load, software may edit the shadow copy through a write port, ahead of a write-back to the memory. A helper output always presents the check byte that the image needs at its last address. That byte is the two's complement of the modulo-256 sum of bytes 0x00 to 0xFE, as they stand in the shadow store.

Top module: `ee_boot_guard`

## Requirements
- R1: While reset is held, rd_req_o is 1, rd_addr_o is 0, and csum_ok_o and start_en_o are 0.
- R2: Reads go in strictly ascending order from address 0 and only one read is outstanding at a time. rd_addr_o holds while rd_req_o is 1 and rd_valid_i is 0, and it advances by one on each clock where rd_valid_i is 1 and rd_req_o is 1.
- R3: Once the byte at address 0xFF has been accepted, rd_req_o drops to 0 on the next cycle and stays at 0 until reset.
- R4: csum_ok_o is 0 until the last byte is accepted. From the cycle after that it is 1 exactly when the modulo-256 sum of all 256 accepted bytes is 0.
- R5: With managed_i at 0 when the last byte is accepted, start_en_o equals csum_ok_o. A non-zero sum therefore leaves start_en_o at 0.
- R6: With managed_i at 1 when the last byte is accepted, start_en_o becomes 1 on the cycle after it, whatever the sum. csum_ok_o still reports the true verdict.
- R7: cfg_rdata_o shows, with no clock delay, the shadow byte at cfg_raddr_i. That is the byte loaded at that address, or the byte written there later. Every shadow byte is 0 during reset.
- R8: After the load, fix_sum_o equals the two's complement modulo 256 of the sum of shadow bytes 0x00 through 0xFE. For a good image this is the byte stored at 0xFF.
- R9: After the load, a write with cfg_we_i at 1 updates the shadow byte at cfg_addr_i on that clock. fix_sum_o follows from the next cycle. A write to address 0xFF changes the stored byte but leaves fix_sum_o unchanged.
- R10: cfg_we_i is ignored until the load is complete. rd_valid_i is ignored while rd_req_o is 0.
- R11: Once set after the load, csum_ok_o and start_en_o do not change until the next reset, whatever writes follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| managed_i | input | 1 | 1 selects managed operation (checksum does not gate start) |
| rd_req_o | output | 1 | Byte read request, held until the byte arrives |
| rd_addr_o | output | 8 | Address of the requested byte |
| rd_valid_i | input | 1 | Requested byte present on rd_data_i this cycle |
| rd_data_i | input | 8 | Returned image byte |
| cfg_we_i | input | 1 | Shadow write strobe, honoured only after the load |
| cfg_addr_i | input | 8 | Shadow write address |
| cfg_wdata_i | input | 8 | Shadow write data |
| cfg_raddr_i | input | 8 | Shadow read address |
| cfg_rdata_o | output | 8 | Shadow byte at cfg_raddr_i |
| fix_sum_o | output | 8 | Check byte that makes the shadow image sum to zero |
| csum_ok_o | output | 1 | Image summed to zero (valid after the load) |
| start_en_o | output | 1 | Device may leave reset |

## Verification
The bench loads images with read latencies from zero to three cycles. A latency of zero means the byte comes back on every cycle. A design that advanced its address while a read was still pending, or that missed a back-to-back byte, would fall out of step with the bench's address model at once. The bench feeds both good and corrupt images in both modes, and an all-zero image as well. A start-enable wired straight to the verdict fails the managed corrupt case. A start-enable that ignores the verdict fails the unmanaged corrupt case. Writes during the load and a stray valid pulse after it are injected to catch a design that accepts either one. After the load, edits that include the check address catch a helper sum that counts byte 0xFF or that misses the old value it replaces.

// File: rtl/ee_boot_pkg.sv
package ee_boot_pkg;

  typedef enum logic {
    ST_FETCH = 1'b0,
    ST_DONE  = 1'b1
  } boot_state_e;

endpackage

// File: rtl/ee_boot_seq.sv
module ee_boot_seq
  import ee_boot_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              managed_i,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              accept_o,
  output logic              done_o,
  output logic              ok_o,
  output logic              start_o,
  output logic              managed_q_o
);

  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  // modulo 2^DATA_W accumulation
  function automatic logic [DATA_W-1:0] acc_add(input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic sum_is_zero(input logic [DATA_W-1:0] s);
    return (s == '0);
  endfunction

  boot_state_e       state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] acc_next;
  logic              ok_q;
  logic              start_q;
  logic              mgd_q;
  logic              accept;
  logic              last_beat;

  assign accept    = (state_q == ST_FETCH) && rd_valid_i;
  assign last_beat = accept && (addr_q == LAST);
  assign acc_next  = acc_add(acc_q, rd_data_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      addr_q  <= '0;
      acc_q   <= '0;
      ok_q    <= 1'b0;
      start_q <= 1'b0;
      mgd_q   <= 1'b0;
    end else if (accept) begin
      acc_q <= acc_next;
      if (last_beat) begin
        state_q <= ST_DONE;
        ok_q    <= sum_is_zero(acc_next);
        start_q <= managed_i | sum_is_zero(acc_next);
        mgd_q   <= managed_i;
      end else begin
        addr_q <= addr_q + 1'b1;
      end
    end
  end

  assign rd_req_o    = (state_q == ST_FETCH);
  assign rd_addr_o   = addr_q;
  assign accept_o    = accept;
  assign done_o      = (state_q == ST_DONE);
  assign ok_o        = ok_q;
  assign start_o     = start_q;
  assign managed_q_o = mgd_q;

endmodule

// File: rtl/ee_boot_shadow.sv
module ee_boot_shadow #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] fix_o
);

  localparam int                DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST  = {ADDR_W{1'b1}};

  // swap one term of a running modulo sum
  function automatic logic [DATA_W-1:0] sum_swap(input logic [DATA_W-1:0] s,
                                                 input logic [DATA_W-1:0] old_b,
                                                 input logic [DATA_W-1:0] new_b);
    return s - old_b + new_b;
  endfunction

  function automatic logic [DATA_W-1:0] twos_neg(input logic [DATA_W-1:0] s);
    return (~s) + 1'b1;
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] body_q;
  logic              wen;
  logic [ADDR_W-1:0] waddr;
  logic [DATA_W-1:0] wdata;

  // load and edit never overlap: edits are gated to the done state upstream
  assign wen   = ld_en_i | wr_en_i;
  assign waddr = ld_en_i ? ld_addr_i : wr_addr_i;
  assign wdata = ld_en_i ? ld_data_i : wr_data_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wen) begin
      mem[waddr] <= wdata;
    end
  end

  // running sum of every byte except the check byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      body_q <= '0;
    end else if (wen && (waddr != LAST)) begin
      body_q <= sum_swap(body_q, mem[waddr], wdata);
    end
  end

  assign rd_data_o = mem[rd_addr_i];
  assign fix_o     = twos_neg(body_q);

endmodule

// File: rtl/ee_boot_guard.sv
module ee_boot_guard #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              managed_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic [ADDR_W-1:0] cfg_raddr_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  output logic [DATA_W-1:0] fix_sum_o,
  output logic              csum_ok_o,
  output logic              start_en_o
);

  // named internal events
  logic boot_accept;
  logic boot_done;
  logic mode_latched;
  logic wr_ok;

  ee_boot_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .managed_i   (managed_i),
    .rd_valid_i  (rd_valid_i),
    .rd_data_i   (rd_data_i),
    .rd_req_o    (rd_req_o),
    .rd_addr_o   (rd_addr_o),
    .accept_o    (boot_accept),
    .done_o      (boot_done),
    .ok_o        (csum_ok_o),
    .start_o     (start_en_o),
    .managed_q_o (mode_latched)
  );

  assign wr_ok = cfg_we_i & boot_done;

  ee_boot_shadow #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_en_i   (boot_accept),
    .ld_addr_i (rd_addr_o),
    .ld_data_i (rd_data_i),
    .wr_en_i   (wr_ok),
    .wr_addr_i (cfg_addr_i),
    .wr_data_i (cfg_wdata_i),
    .rd_addr_i (cfg_raddr_i),
    .rd_data_o (cfg_rdata_o),
    .fix_o     (fix_sum_o)
  );

endmodule

// File: rtl/ee_boot_guard_chk.sv
module ee_boot_guard_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_valid_i,
  input logic              cfg_we_i,
  input logic [ADDR_W-1:0] cfg_addr_i,
  input logic [DATA_W-1:0] fix_sum_o,
  input logic              csum_ok_o,
  input logic              start_en_o,
  input logic              boot_accept,
  input logic              boot_done,
  input logic              mode_latched,
  input logic              wr_ok
);

  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_valid_i) |=> $stable(rd_addr_o)); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_accept && rd_addr_o != LAST) |=> (rd_addr_o == ADDR_W'($past(rd_addr_o) + 1'b1))); // R2

  AST_REQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |-> !rd_req_o); // R3

  AST_OK_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    csum_ok_o |-> boot_done); // R4

  AST_UNMANAGED_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_done && !mode_latched) |-> (start_en_o == csum_ok_o)); // R5

  AST_START_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_en_o && !csum_ok_o) |-> mode_latched); // R6

  AST_VERDICT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_done && $past(boot_done)) |-> ($stable(csum_ok_o) && $stable(start_en_o))); // R11

  AST_FIX_SKIPS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && cfg_addr_i == LAST) |=> $stable(fix_sum_o)); // R9

  AST_EDIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |-> (cfg_we_i && boot_done)); // R10

endmodule

bind ee_boot_guard ee_boot_guard_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_req_o     (rd_req_o),
  .rd_addr_o    (rd_addr_o),
  .rd_valid_i   (rd_valid_i),
  .cfg_we_i     (cfg_we_i),
  .cfg_addr_i   (cfg_addr_i),
  .fix_sum_o    (fix_sum_o),
  .csum_ok_o    (csum_ok_o),
  .start_en_o   (start_en_o),
  .boot_accept  (boot_accept),
  .boot_done    (boot_done),
  .mode_latched (mode_latched),
  .wr_ok        (wr_ok)
);

// File: tb/ee_boot_guard_test.sv
`timescale 1ns/1ps
module ee_boot_guard_test;

  localparam int AW = 8;
  localparam int DW = 8;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          managed_i = 1'b0;
  logic          rd_req_o;
  logic [AW-1:0] rd_addr_o;
  logic          rd_valid_i = 1'b0;
  logic [DW-1:0] rd_data_i = '0;
  logic          cfg_we_i = 1'b0;
  logic [AW-1:0] cfg_addr_i = '0;
  logic [DW-1:0] cfg_wdata_i = '0;
  logic [AW-1:0] cfg_raddr_i = '0;
  logic [DW-1:0] cfg_rdata_o;
  logic [DW-1:0] fix_sum_o;
  logic          csum_ok_o;
  logic          start_en_o;

  always #2.5 clk = ~clk;

  ee_boot_guard #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .managed_i(managed_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
    .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .cfg_raddr_i(cfg_raddr_i), .cfg_rdata_o(cfg_rdata_o),
    .fix_sum_o(fix_sum_o), .csum_ok_o(csum_ok_o), .start_en_o(start_en_o)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // behavioural reference state
  int img [N];
  int sh  [N];
  int m_addr;
  int m_sum;
  bit m_done, m_ok, m_start, wrote;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int want_fix();
    int s = 0;
    for (int i = 0; i < N - 1; i++) s += sh[i];
    return (256 - (s % 256)) % 256;
  endfunction

  // apply the inputs the last rising edge captured
  task automatic step_model();
    if (!m_done && rd_valid_i) begin
      sh[m_addr] = int'(rd_data_i);
      m_sum = (m_sum + int'(rd_data_i)) % 256;
      if (m_addr == N - 1) begin
        m_done  = 1;
        m_ok    = (m_sum == 0);
        m_start = m_ok || managed_i;
      end else begin
        m_addr++;
      end
    end else if (m_done && cfg_we_i) begin
      sh[cfg_addr_i] = int'(cfg_wdata_i);
    end
  endtask

  task automatic compare();
    chk("R3 rd_req", int'(rd_req_o), int'(!m_done));
    if (!m_done) chk("R2 rd_addr", int'(rd_addr_o), m_addr);
    chk(m_done ? "R11 csum_ok" : "R4 csum_ok", int'(csum_ok_o), int'(m_ok));
    chk(managed_i ? "R6 start_en" : "R5 start_en", int'(start_en_o), int'(m_start));
    chk("R7 cfg_rdata", int'(cfg_rdata_o), sh[cfg_raddr_i]);
    if (m_done) chk(wrote ? "R9 fix_sum" : "R8 fix_sum", int'(fix_sum_o), want_fix());
  endtask

  task automatic tick();
    @(negedge clk);
    step_model();
    compare();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rd_valid_i = 1'b0; cfg_we_i = 1'b0; cfg_raddr_i = '0;
    repeat (3) @(negedge clk);
    chk("R1 rd_req in reset", int'(rd_req_o), 1);
    chk("R1 rd_addr in reset", int'(rd_addr_o), 0);
    chk("R1 csum_ok in reset", int'(csum_ok_o), 0);
    chk("R1 start_en in reset", int'(start_en_o), 0);
    m_addr = 0; m_sum = 0; m_done = 0; m_ok = 0; m_start = 0; wrote = 0;
    for (int i = 0; i < N; i++) sh[i] = 0;
    rst_n = 1'b1;
  endtask

  task automatic make_img(input int seed, input int mode);
    int s;
    s = 0;
    for (int i = 0; i < N; i++) img[i] = (seed == 0) ? 0 : ((i * seed + (i >> 3) * 7 + 3) % 256);
    for (int i = 0; i < N - 1; i++) s += img[i];
    if (mode == 1) img[N-1] = (256 - (s % 256)) % 256;
    if (mode == 2) img[N-1] = (257 - (s % 256)) % 256;
  endtask

  task automatic boot(input int lat, input bit mgd, input bit poke);
    int cnt = 0;
    managed_i = mgd;
    while (!m_done) begin
      if (cnt >= lat) begin
        rd_valid_i = 1'b1; rd_data_i = DW'(img[m_addr]); cnt = 0;
      end else begin
        rd_valid_i = 1'b0; cnt++;
      end
      if (poke) begin
        cfg_we_i = 1'b1; cfg_addr_i = AW'(m_addr ^ 8'h55); cfg_wdata_i = 8'hA5;
      end
      cfg_raddr_i = AW'(m_addr);
      tick();
    end
    rd_valid_i = 1'b0; cfg_we_i = 1'b0;
    tick();
  endtask

  task automatic edit(input int a, input int v);
    cfg_we_i = 1'b1; cfg_addr_i = AW'(a); cfg_wdata_i = DW'(v); cfg_raddr_i = AW'(a);
    wrote = 1;
    tick();
    cfg_we_i = 1'b0;
    tick();
  endtask

  initial begin
    int f0;
    // run 1: unmanaged, good image, back-to-back bytes
    do_reset();
    make_img(37, 1);
    boot(0, 0, 0);
    chk("R4 good image verdict", int'(csum_ok_o), 1);
    chk("R5 good image start", int'(start_en_o), 1);
    chk("R8 fix equals stored check byte", int'(fix_sum_o), img[N-1]);
    edit(8'h10, 8'h3C);
    edit(8'h00, 8'hFF);
    edit(8'hFE, 8'h01);
    f0 = int'(fix_sum_o);
    edit(8'hFF, 8'h77);
    chk("R9 check-address write keeps fix", int'(fix_sum_o), f0);
    chk("R11 verdict after edits", int'(csum_ok_o), 1);
    rd_valid_i = 1'b1; rd_data_i = 8'h4D;
    tick();
    rd_valid_i = 1'b0;
    tick();
    chk("R10 stray valid keeps req low", int'(rd_req_o), 0);
    chk("R10 stray valid keeps fix", int'(fix_sum_o), f0);

    // run 2: unmanaged, corrupt image, latency 2, edits during load
    do_reset();
    make_img(11, 2);
    boot(2, 0, 1);
    chk("R4 bad image verdict", int'(csum_ok_o), 0);
    chk("R5 bad image holds start", int'(start_en_o), 0);
    cfg_raddr_i = 8'h55;
    tick();
    chk("R10 load-time write ignored", int'(cfg_rdata_o), img[8'h55]);

    // run 3: managed, corrupt image, latency 1
    do_reset();
    make_img(23, 2);
    boot(1, 1, 0);
    chk("R6 managed start despite bad sum", int'(start_en_o), 1);
    chk("R6 managed verdict still low", int'(csum_ok_o), 0);

    // run 4: unmanaged, all-zero image, latency 3
    do_reset();
    make_img(0, 0);
    boot(3, 0, 0);
    chk("R4 zero image verdict", int'(csum_ok_o), 1);
    chk("R8 zero image fix", int'(fix_sum_o), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R3 actual=hung expected=load complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule